// File: doc/BRIEF.md
# Static LCD Segment Capture Decoder

This block listens to a four-digit, statically driven seven-segment LCD from the outside and turns what the panel shows into packed BCD. Such a panel drives every segment and the common backplane with square waves. A segment that is dark moves in phase with the backplane. A segment that is visible moves against it. The block runs from a fast system clock and brings every line through a synchronizer. It accepts a backplane transition only after that transition has held for a set number of clocks.

After the chosen transition is accepted, the block lets a settling interval pass. This keeps skew between the common and segment drivers away from the sample. It then takes one snapshot of all segment lines and compares each one with the backplane level at that instant. Each digit is decoded on its own, and a digit whose pattern has no meaning is flagged.

The 16-bit result is announced with a one-cycle strobe. The block then stays deaf to the panel until the downstream sender reports that it has shipped the word. After that report the block arms again for the next trigger transition.

Top module: `lcdsnoop_top`

## Requirements
- R1: While reset is held, and on leaving it, `result` and `digitInvalid` are zero, `resultValid` is low and `ready` is high.
- R2: At the sampling instant, a segment counts as lit when its synchronized level differs from the synchronized backplane level. Segment order within a digit is a = bit 0 up to g = bit 6. The lit sets are: 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg, 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc, 8 = abcdefg, 9 = abcdfg. These decode correctly whether the backplane is high or low when the sample is taken.
- R3: A digit whose lit set matches none of the ten glyphs raises its bit of `digitInvalid`, and its nibble reads 4'hF.
- R4: A capture starts only on an accepted backplane transition toward the trigger level (high when `TRIG_RISING` is 1, low otherwise). An accepted transition the other way starts nothing.
- R5: A backplane excursion that lasts fewer than `STABLE_CYC` clocks is discarded. It produces no strobe and leaves `ready` high.
- R6: `resultValid` is high exactly SYNC_STAGES + STABLE_CYC + DELAY_CYC + 1 clock edges after the first edge at which a trigger change is present on `bpIn`.
- R7: `resultValid` lasts one cycle. `ready` is low from the accepted trigger transition until `txDone`. Backplane transitions and segment changes in that interval cause no new strobe.
- R8: A `txDone` pulse while a result is waiting raises `ready` on the next cycle. The next trigger transition is then captured normally.
- R9: `result` and `digitInvalid` change only in a cycle in which `resultValid` is high.
- R10: Digit k is read from `segIn[7k+6:7k]`. It lands in `result[4k+3:4k]` and in `digitInvalid[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| segIn | input | DIGITS*7 | Raw segment drive lines, digit k on bits 7k..7k+6 (a..g) |
| bpIn | input | 1 | Raw common backplane line |
| txDone | input | 1 | Pulse from the downstream sender: the word has been sent |
| result | output | DIGITS*4 | Packed BCD word, digit k in nibble k |
| digitInvalid | output | DIGITS | Per-digit flag for an unrecognised pattern |
| resultValid | output | 1 | One-cycle strobe: a new word is on `result` |
| ready | output | 1 | High while the block waits for a trigger transition |

## Verification
The bench builds the block with a four-clock stability filter and a twenty-clock settling delay, triggering on the rising transition. With these short values the exact strobe latency can be counted edge by edge, and many frames fit in a short run. Because the delay is short, the bench can also return the backplane to low after the rising transition has been accepted but before the sample is taken. This exercises decoding with the backplane at both levels. The bench also sends a backplane pulse two clocks shorter than the filter window, which probes the noise-rejection boundary.

// File: rtl/lcdsnoop_pkg.sv
package lcdsnoop_pkg;

  localparam int SEG_PER_DIGIT = 7;
  localparam int BCD_W         = 4;

  typedef enum logic [1:0] {
    ST_ARM,
    ST_WAIT,
    ST_HOLD
  } snoopState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;
  } ctlStrobe_t;

  // lit set (a = bit 0 .. g = bit 6) -> {invalid, bcd}
  function automatic logic [4:0] decodeGlyph(input logic [6:0] lit);
    logic [4:0] res;
    case (lit)
      7'h3F:   res = 5'h00;
      7'h06:   res = 5'h01;
      7'h5B:   res = 5'h02;
      7'h4F:   res = 5'h03;
      7'h66:   res = 5'h04;
      7'h6D:   res = 5'h05;
      7'h7D:   res = 5'h06;
      7'h07:   res = 5'h07;
      7'h7F:   res = 5'h08;
      7'h6F:   res = 5'h09;
      default: res = 5'h1F;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/lcdsnoop_dp.sv
module lcdsnoop_dp
  import lcdsnoop_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 16,
  parameter bit TRIG_RISING = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DIGITS*SEG_PER_DIGIT-1:0] segIn,
  input  logic                      bpIn,
  input  ctlStrobe_t                ctl,
  output logic                      trigEdge,
  output logic [DIGITS*BCD_W-1:0]   result,
  output logic [DIGITS-1:0]         digitInvalid,
  output logic                      resultValid
);

  localparam int SEGW  = DIGITS * SEG_PER_DIGIT;
  localparam int STB_W = $clog2(STABLE_CYC + 1);

  // synchronizer chain for backplane and all segment lines together
  logic [SYNC_STAGES-1:0][SEGW:0] syncPipe;
  logic                           bpSync;
  logic [SEGW-1:0]                segSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], {bpIn, segIn}};
  end

  assign bpSync  = syncPipe[SYNC_STAGES-1][SEGW];
  assign segSync = syncPipe[SYNC_STAGES-1][SEGW-1:0];

  // stability filter on the backplane
  logic             bpStable;
  logic [STB_W-1:0] stbCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpStable <= 1'b0;
      stbCnt   <= '0;
      trigEdge <= 1'b0;
    end else begin
      trigEdge <= 1'b0;
      if (bpSync == bpStable) begin
        stbCnt <= '0;
      end else if (stbCnt == STB_W'(STABLE_CYC - 1)) begin
        bpStable <= bpSync;
        stbCnt   <= '0;
        trigEdge <= (bpSync == TRIG_RISING);
      end else begin
        stbCnt <= stbCnt + 1'b1;
      end
    end
  end

  // phase recovery and per-digit decode
  logic [SEGW-1:0]         litVec;
  logic [DIGITS*BCD_W-1:0] nextResult;
  logic [DIGITS-1:0]       nextInvalid;

  assign litVec = segSync ^ {SEGW{bpSync}};

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    assign {nextInvalid[k], nextResult[k*BCD_W +: BCD_W]} =
      decodeGlyph(litVec[k*SEG_PER_DIGIT +: SEG_PER_DIGIT]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      digitInvalid <= '0;
      resultValid  <= 1'b0;
    end else begin
      resultValid <= ctl.sample;
      if (ctl.sample) begin
        result       <= nextResult;
        digitInvalid <= nextInvalid;
      end
    end
  end

endmodule

// File: rtl/lcdsnoop_ctrl.sv
module lcdsnoop_ctrl
  import lcdsnoop_pkg::*;
#(
  parameter int DELAY_CYC = 250000,
  parameter int DELAY_W   = 21
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigEdge,
  input  logic       txDone,
  output ctlStrobe_t ctl,
  output logic       ready
);

  snoopState_e        state;
  logic [DELAY_W-1:0] dlyCnt;
  logic               dlyDone;

  assign dlyDone    = (dlyCnt == DELAY_W'(DELAY_CYC - 1));
  assign ctl.sample = (state == ST_WAIT) && dlyDone;
  assign ready      = (state == ST_ARM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_ARM;
      dlyCnt <= '0;
    end else begin
      case (state)
        ST_ARM: begin
          dlyCnt <= '0;
          if (trigEdge) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dlyDone) state  <= ST_HOLD;
          else         dlyCnt <= dlyCnt + 1'b1;
        end
        ST_HOLD: begin
          if (txDone) state <= ST_ARM;
        end
        default: state <= ST_ARM;
      endcase
    end
  end

endmodule

// File: rtl/lcdsnoop_top.sv
module lcdsnoop_top
  import lcdsnoop_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 16,
  parameter int DELAY_CYC   = 250000,
  parameter int DELAY_W     = 21,
  parameter bit TRIG_RISING = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DIGITS*7-1:0]     segIn,
  input  logic                    bpIn,
  input  logic                    txDone,
  output logic [DIGITS*4-1:0]     result,
  output logic [DIGITS-1:0]       digitInvalid,
  output logic                    resultValid,
  output logic                    ready
);

  ctlStrobe_t ctl;
  logic       trigEdge;

  lcdsnoop_dp #(
    .DIGITS(DIGITS), .SYNC_STAGES(SYNC_STAGES),
    .STABLE_CYC(STABLE_CYC), .TRIG_RISING(TRIG_RISING)
  ) u_dp (
    .clk(clk), .rstN(rstN), .segIn(segIn), .bpIn(bpIn), .ctl(ctl),
    .trigEdge(trigEdge), .result(result), .digitInvalid(digitInvalid),
    .resultValid(resultValid)
  );

  lcdsnoop_ctrl #(
    .DELAY_CYC(DELAY_CYC), .DELAY_W(DELAY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigEdge(trigEdge), .txDone(txDone),
    .ctl(ctl), .ready(ready)
  );

endmodule

// File: rtl/lcdsnoop_chk.sv
module lcdsnoop_chk #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                txDone,
  input logic [DIGITS*4-1:0] result,
  input logic [DIGITS-1:0]   digitInvalid,
  input logic                resultValid,
  input logic                ready
);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !ready);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !txDone) |=> !ready);

  p_no_instant_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> !resultValid);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(result) && $stable(digitInvalid)));

  for (genvar k = 0; k < DIGITS; k++) begin : g_bad
    p_bad_nibble_r3: assert property (@(posedge clk) disable iff (!rstN)
      digitInvalid[k] |-> (result[k*4 +: 4] == 4'hF));
  end

endmodule

bind lcdsnoop_top lcdsnoop_chk #(.DIGITS(DIGITS)) u_chk (
  .clk(clk), .rstN(rstN), .txDone(txDone), .result(result),
  .digitInvalid(digitInvalid), .resultValid(resultValid), .ready(ready)
);

// File: tb/lcdsnoop_top_tb.sv
module lcdsnoop_top_tb;

  localparam int DIG = 4;
  localparam int SYN = 2;
  localparam int STB = 4;
  localparam int DLY = 20;
  localparam int LAT = SYN + STB + DLY + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DIG*7-1:0]  segIn = '0;
  logic              bpIn = 1'b0;
  logic              txDone = 1'b0;
  logic [DIG*4-1:0]  result;
  logic [DIG-1:0]    digitInvalid;
  logic              resultValid;
  logic              ready;

  int  nChecks = 0;
  int  nFails  = 0;

  always #4 clk = ~clk;

  lcdsnoop_top #(
    .DIGITS(DIG), .SYNC_STAGES(SYN), .STABLE_CYC(STB),
    .DELAY_CYC(DLY), .DELAY_W(8), .TRIG_RISING(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .segIn(segIn), .bpIn(bpIn), .txDone(txDone),
    .result(result), .digitInvalid(digitInvalid),
    .resultValid(resultValid), .ready(ready)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] glyph(input logic [3:0] n);
    case (n)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [DIG*7-1:0] litWord(input logic [DIG*4-1:0] bcd);
    logic [DIG*7-1:0] w;
    for (int k = 0; k < DIG; k++) w[k*7 +: 7] = glyph(bcd[k*4 +: 4]);
    return w;
  endfunction

  // watch n cycles: no strobe, outputs unchanged
  task automatic quiet(input int n, input string tag, input logic expReady);
    int strobes = 0;
    logic [DIG*4-1:0] holdRes = result;
    logic [DIG-1:0]   holdInv = digitInvalid;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (resultValid) strobes++;
    end
    check(strobes == 0, {tag, " no strobe"}, strobes, 0);
    check(result == holdRes && digitInvalid == holdInv, "R9 outputs held",
          {result, digitInvalid}, {holdRes, holdInv});
    check(ready == expReady, {tag, " ready"}, ready, expReady);
  endtask

  task automatic frame(input logic [DIG*7-1:0] lit, input logic [DIG*4-1:0] expRes,
                       input logic [DIG-1:0] expInv, input bit fastFlip);
    int lat = 0;
    // falling transition must not start a capture (R4)
    @(negedge clk);
    bpIn = 1'b0; segIn = lit;
    quiet(LAT + 10, "R4 falling edge", 1'b1);
    // rising transition, segments inverted against a high backplane
    @(negedge clk);
    bpIn = 1'b1; segIn = lit ^ {DIG*7{1'b1}};
    while (lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
      if (fastFlip && lat == STB + 6) begin
        bpIn = 1'b0; segIn = lit;   // R2: low backplane at the sample
      end
      if (resultValid) break;
    end
    check(lat == LAT, "R6 latency", lat, LAT);
    check(result == expRes, "R2 R10 decoded word", result, expRes);
    check(digitInvalid == expInv, "R3 R10 invalid flags", digitInvalid, expInv);
    check(!ready, "R7 busy at strobe", ready, 0);
    @(negedge clk);
    check(!resultValid, "R7 single-cycle strobe", resultValid, 0);
    // edges while waiting for the sender are ignored (R7)
    bpIn = 1'b0; segIn = ~lit;
    repeat (STB + 4) @(negedge clk);
    bpIn = 1'b1;
    quiet(LAT + 10, "R7 held", 1'b0);
    // release (R8)
    txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
    check(ready, "R8 rearm after txDone", ready, 1);
  endtask

  task automatic glitchTest();
    @(negedge clk);
    bpIn = 1'b0;
    quiet(LAT + 10, "R5 settle low", 1'b1);
    bpIn = 1'b1;
    repeat (STB - 2) @(negedge clk);
    bpIn = 1'b0;
    quiet(LAT + 10, "R5 short pulse", 1'b1);
  endtask

  task automatic resetTest();
    repeat (3) @(negedge clk);
    check(result == '0, "R1 result", result, 0);
    check(digitInvalid == '0, "R1 invalid", digitInvalid, 0);
    check(!resultValid, "R1 valid", resultValid, 0);
    check(ready, "R1 ready", ready, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(ready && !resultValid && result == '0, "R1 after release",
          {ready, resultValid, result}, {1'b1, 1'b0, 16'h0});
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    logic [DIG*7-1:0] badLit;
    resetTest();
    frame(litWord(16'h1234), 16'h1234, 4'b0000, 1'b0);
    frame(litWord(16'h5678), 16'h5678, 4'b0000, 1'b1);
    frame(litWord(16'h9090), 16'h9090, 4'b0000, 1'b0);
    frame(litWord(16'h0981), 16'h0981, 4'b0000, 1'b1);
    // R3: blank digit 1 and an "E" shape on digit 3
    badLit = litWord(16'h0000);
    badLit[7 +: 7]  = 7'h00;
    badLit[21 +: 7] = 7'h79;
    frame(badLit, 16'hF0F0, 4'b1010, 1'b0);
    glitchTest();
    frame(litWord(16'h7405), 16'h7405, 4'b0000, 1'b0);
    finishRun();
  end

  initial begin
    #(8 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    finishRun();
  end

endmodule